// File: doc/BRIEF.md
# Power-Mode State Controller

This block tracks the mission power state of a multi-rail power-management device and drives the enables of its three rail groups: the safety-microcontroller group, the main-processor group and the retention group. It also drives the external driver enable. When the device hands control over from its fixed hardware state machine, the controller runs a one-cycle initialization step. It then waits in STANDBY for an ON request. From there, mode requests move it between full power, microcontroller-only power and retention.

A SoC power error puts the device into a restricted error state. That state ignores every trigger except a request to go back to microcontroller-only power. Severe and orderly faults shut all rails off and hand the device over to a recovery indication. The next hand-over re-initializes the controller and brings it back to STANDBY.

Every transition between mission states starts a programmable busy window that stands for the length of the rail sequence. Triggers are only acted on once that window has expired. Retention can only be entered when at least one of two select bits in a small control register is already set. Those bits are sampled when the retention request is accepted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `state_o` is 0 (OFF). All enables, `busy_o`, `safe_rec_o`, `init_done_o` and `rv_chk_dis_o` are 0, `uv_ov_mask_o` is 1 and `cfg_q_o` is 0.
- R2: In OFF (0) or SAFE_REC (8), `fsm_entry_i` moves the state to INIT (1) at the next edge, and INIT always moves to STANDBY (2) one edge later. From the cycle that first shows STANDBY, `init_done_o`=1, `rv_chk_dis_o`=1 and `uv_ov_mask_o`=0, and `init_done_o` never falls again.
- R3: In STANDBY all three rail enables and `drv_en_o` are 0, even when the driver-control bit `cfg_q_o[0]` is 1. An asserted `on_req_i` moves STANDBY to ACTIVE (3).
- R4: In ACTIVE the MCU, main and retention enables are 1, and `drv_en_o` equals `cfg_q_o[0]`.
- R5: In MCU_ONLY (4) and SOC_ERR (5) the main enable is 0, the MCU and retention enables are 1, and `drv_en_o` equals `cfg_q_o[0]`.
- R6: With `mode_vld_i`=1 in ACTIVE, MCU_ONLY or RETENTION (6), `mode_i` selects the target state: 0 selects ACTIVE, 1 selects MCU_ONLY and 2 selects RETENTION. Code 3, and a code naming the current state, cause no transition.
- R7: A `soc_err_i` in ACTIVE or MCU_ONLY enters SOC_ERR. In SOC_ERR only `mode_vld_i` with `mode_i`=1 is accepted, and it leads to MCU_ONLY. Faults, a dropped `on_req_i` and the other mode codes are ignored there.
- R8: A retention request is accepted only if `cfg_q_o[1]` (GPIO select) or `cfg_q_o[2]` (DDR select) is 1. On acceptance both bits are sampled onto `ret_gpio_o`/`ret_ddr_o`, which then hold through RETENTION, and `cfg_q_o[0]` is cleared. In RETENTION only the retention enable is 1.
- R9: A deasserted `on_req_i` in ACTIVE, MCU_ONLY or RETENTION moves the state to STANDBY.
- R10: `severe_i` or `orderly_i` in STANDBY, ACTIVE, MCU_ONLY or RETENTION enters TO_SAFE (7) with all enables 0, followed by SAFE_REC (8) with `safe_rec_o`=1. TO_SAFE lasts 1 cycle for a severe fault and `seq_cycles_i`+1 cycles for an orderly fault.
- R11: Every mission transition, including the entry to SOC_ERR and the orderly entry to TO_SAFE, holds `busy_o` high for `seq_cycles_i` cycles. While `busy_o` is 1 the state does not change.
- R12: When triggers coincide, the order of precedence is severe fault, orderly fault, SoC power error, dropped ON request, mode request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsm_entry_i | input | 1 | Hand-over from the fixed hardware state machine |
| on_req_i | input | 1 | ON request, level |
| mode_vld_i | input | 1 | Mode request valid |
| mode_i | input | 2 | Requested mode: 0 active, 1 MCU-only, 2 retention, 3 reserved |
| soc_err_i | input | 1 | SoC power error trigger |
| severe_i | input | 1 | Severe fault trigger |
| orderly_i | input | 1 | Orderly fault trigger |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 3 | Control write data: bit 0 driver control, bit 1 GPIO select, bit 2 DDR select |
| seq_cycles_i | input | CNT_W | Busy window length per transition |
| state_o | output | 4 | Current state code |
| mcu_en_o | output | 1 | MCU rail group enable |
| main_en_o | output | 1 | Main rail group enable |
| ret_en_o | output | 1 | Retention rail group enable |
| drv_en_o | output | 1 | External driver enable |
| ret_gpio_o | output | 1 | GPIO retention flavor active |
| ret_ddr_o | output | 1 | DDR retention flavor active |
| busy_o | output | 1 | Transition sequence in progress |
| safe_rec_o | output | 1 | Recovery hand-over indication |
| init_done_o | output | 1 | First initialization completed |
| rv_chk_dis_o | output | 1 | Residual-voltage checks disabled |
| uv_ov_mask_o | output | 1 | Supply over/under-voltage masks set |
| cfg_q_o | output | 3 | Control register contents |

## Verification
The assertions check several properties on every cycle. The main group is never on without the MCU group. The safe and standby states stay dark. SOC_ERR only ever exits to MCU_ONLY. The state never moves while `busy_o` is high. Retention always has a flavor selected, and that flavor cannot change while retention lasts. The initialization flag never falls.

Other behaviours can only be shown by the bench's scenarios. These are the exact busy and TO_SAFE durations, the order of precedence among coinciding triggers, the rejection of a retention request without a select bit, and the clearing of the driver-control bit at retention entry.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-mode controller: state and mode codes and
// control register bit positions. The state codes are visible on state_o.
package pwr_mode_pkg;

    typedef enum logic [3:0] {
        PM_OFF     = 4'd0,
        PM_INIT    = 4'd1,
        PM_STANDBY = 4'd2,
        PM_ACTIVE  = 4'd3,
        PM_MCU     = 4'd4,
        PM_SOCERR  = 4'd5,
        PM_RETAIN  = 4'd6,
        PM_TOSAFE  = 4'd7,
        PM_SAFEREC = 4'd8
    } pm_state_e;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_MCU    = 2'd1,
        MODE_RETAIN = 2'd2,
        MODE_RSVD   = 2'd3
    } pm_mode_e;

    localparam int CFG_W    = 3;
    localparam int CFG_DRV  = 0;
    localparam int CFG_GPIO = 1;
    localparam int CFG_DDR  = 2;

endpackage

// File: rtl/pwr_mode_seq_timer.sv
`timescale 1ns/1ps
// Busy-window counter. A load sets the remaining cycle count, and the
// counter then runs down to zero. busy_o is high while the count is nonzero.
// Assumes the load has priority over the countdown.
module pwr_mode_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a transition, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while any cycles remain.
    always_comb begin
        busy_o = (cnt_q != '0);
    end

endmodule

// File: rtl/pwr_mode_arb.sv
`timescale 1ns/1ps
// Next-state arbiter. It picks at most one transition per cycle from the
// current state and the triggers, in fixed precedence: severe, orderly,
// SoC error, dropped ON request, mode request. Outside the hand-over states
// nothing is taken while busy_i is high. Purely combinational.
module pwr_mode_arb
    import pwr_mode_pkg::*;
(
    input  pm_state_e  state_i,
    input  logic       busy_i,
    input  logic       fsm_entry_i,
    input  logic       on_req_i,
    input  logic       mode_vld_i,
    input  pm_mode_e   mode_i,
    input  logic       soc_err_i,
    input  logic       severe_i,
    input  logic       orderly_i,
    input  logic       sel_any_i,
    output pm_state_e  nxt_o,
    output logic       take_o,
    output logic       use_seq_o
);

    logic socerr_ok;
    logic mode_hit;
    pm_state_e mode_tgt;

    // Map the requested mode code to a target state and validate it.
    always_comb begin
        mode_tgt = state_i;
        mode_hit = 1'b0;
        unique case (mode_i)
            MODE_ACTIVE: begin
                mode_tgt = PM_ACTIVE;
                mode_hit = (state_i != PM_ACTIVE);
            end
            MODE_MCU: begin
                mode_tgt = PM_MCU;
                mode_hit = (state_i != PM_MCU);
            end
            MODE_RETAIN: begin
                mode_tgt = PM_RETAIN;
                mode_hit = (state_i != PM_RETAIN) && sel_any_i;
            end
            default: begin
                mode_tgt = state_i;
                mode_hit = 1'b0;
            end
        endcase
    end

    // A SoC error is only meaningful while the processor is powered.
    always_comb begin
        socerr_ok = soc_err_i && ((state_i == PM_ACTIVE) || (state_i == PM_MCU));
    end

    // Pick the transition by state and precedence.
    always_comb begin
        nxt_o     = state_i;
        take_o    = 1'b0;
        use_seq_o = 1'b0;
        unique case (state_i)
            PM_OFF, PM_SAFEREC: begin
                if (fsm_entry_i) begin
                    nxt_o  = PM_INIT;
                    take_o = 1'b1;
                end
            end
            PM_INIT: begin
                nxt_o  = PM_STANDBY;
                take_o = 1'b1;
            end
            PM_TOSAFE: begin
                if (!busy_i) begin
                    nxt_o  = PM_SAFEREC;
                    take_o = 1'b1;
                end
            end
            PM_SOCERR: begin
                if (!busy_i && mode_vld_i && (mode_i == MODE_MCU)) begin
                    nxt_o     = PM_MCU;
                    take_o    = 1'b1;
                    use_seq_o = 1'b1;
                end
            end
            default: begin
                if (!busy_i) begin
                    if (severe_i) begin
                        nxt_o  = PM_TOSAFE;
                        take_o = 1'b1;
                    end else if (orderly_i) begin
                        nxt_o     = PM_TOSAFE;
                        take_o    = 1'b1;
                        use_seq_o = 1'b1;
                    end else if (socerr_ok) begin
                        nxt_o     = PM_SOCERR;
                        take_o    = 1'b1;
                        use_seq_o = 1'b1;
                    end else if (state_i == PM_STANDBY) begin
                        if (on_req_i) begin
                            nxt_o     = PM_ACTIVE;
                            take_o    = 1'b1;
                            use_seq_o = 1'b1;
                        end
                    end else if (!on_req_i) begin
                        nxt_o     = PM_STANDBY;
                        take_o    = 1'b1;
                        use_seq_o = 1'b1;
                    end else if (mode_vld_i && mode_hit) begin
                        nxt_o     = mode_tgt;
                        take_o    = 1'b1;
                        use_seq_o = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_rail_dec.sv
`timescale 1ns/1ps
// Output decoder. It turns the registered state and the sampled control bits
// into rail-group enables, the driver enable and the flavor and recovery
// flags. Assumes the state is a register, so every output is glitch-free
// with respect to the triggers.
module pwr_mode_rail_dec
    import pwr_mode_pkg::*;
(
    input  pm_state_e state_i,
    input  logic      drv_ctl_i,
    input  logic      gpio_sel_i,
    input  logic      ddr_sel_i,
    output logic      mcu_en_o,
    output logic      main_en_o,
    output logic      ret_en_o,
    output logic      drv_en_o,
    output logic      ret_gpio_o,
    output logic      ret_ddr_o,
    output logic      safe_rec_o
);

    // Decode the enables for each state.
    always_comb begin
        mcu_en_o   = 1'b0;
        main_en_o  = 1'b0;
        ret_en_o   = 1'b0;
        drv_en_o   = 1'b0;
        ret_gpio_o = 1'b0;
        ret_ddr_o  = 1'b0;
        safe_rec_o = 1'b0;
        unique case (state_i)
            PM_ACTIVE: begin
                mcu_en_o  = 1'b1;
                main_en_o = 1'b1;
                ret_en_o  = 1'b1;
                drv_en_o  = drv_ctl_i;
            end
            PM_MCU, PM_SOCERR: begin
                mcu_en_o = 1'b1;
                ret_en_o = 1'b1;
                drv_en_o = drv_ctl_i;
            end
            PM_RETAIN: begin
                ret_en_o   = 1'b1;
                ret_gpio_o = gpio_sel_i;
                ret_ddr_o  = ddr_sel_i;
            end
            PM_SAFEREC: begin
                safe_rec_o = 1'b1;
            end
            default: begin
                mcu_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Power-mode state controller, top level. It holds the state register, the
// control register, the initialization flags and the sampled retention
// flavor. The arbiter picks the next state, the timer models the sequence
// length and the decoder drives the rails. Assumes all triggers are
// synchronous levels held until they are acted on.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsm_entry_i,
    input  logic             on_req_i,
    input  logic             mode_vld_i,
    input  logic [1:0]       mode_i,
    input  logic             soc_err_i,
    input  logic             severe_i,
    input  logic             orderly_i,
    input  logic             cfg_wr_i,
    input  logic [2:0]       cfg_wdata_i,
    input  logic [CNT_W-1:0] seq_cycles_i,
    output logic [3:0]       state_o,
    output logic             mcu_en_o,
    output logic             main_en_o,
    output logic             ret_en_o,
    output logic             drv_en_o,
    output logic             ret_gpio_o,
    output logic             ret_ddr_o,
    output logic             busy_o,
    output logic             safe_rec_o,
    output logic             init_done_o,
    output logic             rv_chk_dis_o,
    output logic             uv_ov_mask_o,
    output logic [2:0]       cfg_q_o
);

    pm_state_e        state_q;
    pm_state_e        nxt_state;
    logic             take;
    logic             use_seq;
    logic             busy;
    logic             ret_entry;
    logic [CNT_W-1:0] load_val;
    logic [CFG_W-1:0] cfg_q;
    logic             gpio_q;
    logic             ddr_q;
    logic             init_done_q;
    logic             rv_dis_q;
    logic             mask_q;

    pwr_mode_arb u_arb (
        .state_i     (state_q),
        .busy_i      (busy),
        .fsm_entry_i (fsm_entry_i),
        .on_req_i    (on_req_i),
        .mode_vld_i  (mode_vld_i),
        .mode_i      (pm_mode_e'(mode_i)),
        .soc_err_i   (soc_err_i),
        .severe_i    (severe_i),
        .orderly_i   (orderly_i),
        .sel_any_i   (cfg_q[CFG_GPIO] | cfg_q[CFG_DDR]),
        .nxt_o       (nxt_state),
        .take_o      (take),
        .use_seq_o   (use_seq)
    );

    // Load value for the busy window: the programmed length or nothing.
    always_comb begin
        load_val  = use_seq ? seq_cycles_i : '0;
        ret_entry = take && (nxt_state == PM_RETAIN);
    end

    pwr_mode_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (take),
        .load_val_i (load_val),
        .busy_o     (busy)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_OFF;
        end else if (take) begin
            state_q <= nxt_state;
        end
    end

    // Control register: software writes, and retention entry clears the
    // driver-control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (cfg_wr_i) begin
                cfg_q <= cfg_wdata_i;
            end
            if (ret_entry) begin
                cfg_q[CFG_DRV] <= 1'b0;
                if (cfg_wr_i) begin
                    cfg_q[CFG_GPIO] <= cfg_wdata_i[CFG_GPIO];
                    cfg_q[CFG_DDR]  <= cfg_wdata_i[CFG_DDR];
                end
            end
        end
    end

    // Sample the retention flavor when the retention request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_q <= 1'b0;
            ddr_q  <= 1'b0;
        end else if (ret_entry) begin
            gpio_q <= cfg_q[CFG_GPIO];
            ddr_q  <= cfg_q[CFG_DDR];
        end
    end

    // Initialization actions, applied while the INIT state is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_done_q <= 1'b0;
            rv_dis_q    <= 1'b0;
            mask_q      <= 1'b1;
        end else if (state_q == PM_INIT) begin
            init_done_q <= 1'b1;
            rv_dis_q    <= 1'b1;
            mask_q      <= 1'b0;
        end
    end

    pwr_mode_rail_dec u_dec (
        .state_i    (state_q),
        .drv_ctl_i  (cfg_q[CFG_DRV]),
        .gpio_sel_i (gpio_q),
        .ddr_sel_i  (ddr_q),
        .mcu_en_o   (mcu_en_o),
        .main_en_o  (main_en_o),
        .ret_en_o   (ret_en_o),
        .drv_en_o   (drv_en_o),
        .ret_gpio_o (ret_gpio_o),
        .ret_ddr_o  (ret_ddr_o),
        .safe_rec_o (safe_rec_o)
    );

    // Drive the remaining status outputs.
    always_comb begin
        state_o      = state_q;
        busy_o       = busy;
        init_done_o  = init_done_q;
        rv_chk_dis_o = rv_dis_q;
        uv_ov_mask_o = mask_q;
        cfg_q_o      = cfg_q;
    end

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for pwr_mode_ctrl. It only observes the top-level ports,
// and is attached by the bind statement at the end of this file.
module pwr_mode_ctrl_chk
    import pwr_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] state_o,
    input logic       mcu_en_o,
    input logic       main_en_o,
    input logic       ret_en_o,
    input logic       drv_en_o,
    input logic       ret_gpio_o,
    input logic       ret_ddr_o,
    input logic       busy_o,
    input logic       init_done_o
);

    // R4: the main group never runs without the MCU group.
    a_r4_main_needs_mcu: assert property (@(posedge clk) disable iff (!rst_n)
        main_en_o |-> mcu_en_o);

    // R3: standby is fully dark, including the driver.
    a_r3_standby_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PM_STANDBY) |-> !(mcu_en_o || main_en_o || ret_en_o || drv_en_o));

    // R10: the shutdown and recovery states drive nothing.
    a_r10_safe_dark: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == PM_TOSAFE) || (state_o == PM_SAFEREC))
            |-> !(mcu_en_o || main_en_o || ret_en_o || drv_en_o));

    // R7: the error state is only ever left towards MCU_ONLY.
    a_r7_socerr_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_o) == PM_SOCERR) && (state_o != PM_SOCERR)) |-> (state_o == PM_MCU));

    // R11: no state change while a sequence is running.
    a_r11_busy_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(state_o));

    // R8: retention always carries a flavor, and the driver is off.
    a_r8_ret_flavor: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PM_RETAIN) |-> ((ret_gpio_o || ret_ddr_o) && !drv_en_o));

    // R8: the flavor cannot change while retention lasts.
    a_r8_ret_flavor_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == PM_RETAIN) && ($past(state_o) == PM_RETAIN))
            |-> ($stable(ret_gpio_o) && $stable(ret_ddr_o)));

    // R2: once initialization has run, its flag stays set.
    a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_o     (state_o),
    .mcu_en_o    (mcu_en_o),
    .main_en_o   (main_en_o),
    .ret_en_o    (ret_en_o),
    .drv_en_o    (drv_en_o),
    .ret_gpio_o  (ret_gpio_o),
    .ret_ddr_o   (ret_ddr_o),
    .busy_o      (busy_o),
    .init_done_o (init_done_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
// Testbench for pwr_mode_ctrl. A table of vectors is walked first, with a
// zero-length busy window. Directed tests for reset, retention sampling,
// busy timing and fault precedence follow.
module pwr_mode_ctrl_tb_top;

    localparam int CNT_W = 8;
    localparam int NV    = 24;
    localparam int WD_LIMIT = 5000;

    // {entry, on, vld, mode[1:0], soc, sev, ord, wr, wdata[2:0], exp_state[3:0], exp_rails[3:0]}
    // exp_rails = {mcu, main, ret, drv}
    localparam logic [19:0] VEC [NV] = '{
        20'b1_0_0_00_0_0_0_0_000_0001_0000, // R2 entry -> INIT
        20'b0_0_0_00_0_0_0_0_000_0010_0000, // R2 INIT -> STANDBY
        20'b0_0_0_00_0_0_0_1_001_0010_0000, // R3 drv bit set, still dark
        20'b0_1_0_00_0_0_0_0_000_0011_1111, // R4 ON -> ACTIVE
        20'b0_1_1_01_0_0_0_0_000_0100_1011, // R5 -> MCU_ONLY
        20'b0_1_1_11_0_0_0_0_000_0100_1011, // R6 reserved code ignored
        20'b0_1_0_00_1_0_0_0_000_0101_1011, // R7 SoC error
        20'b0_1_0_00_0_1_0_0_000_0101_1011, // R7 severe ignored
        20'b0_0_0_00_0_0_0_0_000_0101_1011, // R7 ON drop ignored
        20'b0_1_1_00_0_0_0_0_000_0101_1011, // R7 active request ignored
        20'b0_1_1_01_0_0_0_0_000_0100_1011, // R7 exit to MCU_ONLY
        20'b0_1_1_00_0_0_0_0_000_0011_1111, // R6 -> ACTIVE
        20'b0_1_1_10_0_0_0_0_000_0011_1111, // R8 no select, ignored
        20'b0_1_0_00_0_0_0_1_011_0011_1111, // R8 write GPIO select
        20'b0_1_1_10_0_0_0_0_000_0110_0010, // R8 -> RETENTION
        20'b0_1_1_00_0_0_0_0_000_0011_1110, // R4 ACTIVE, drv cleared
        20'b0_1_1_01_1_0_0_0_000_0101_1010, // R12 SoC error over mode
        20'b0_1_1_01_0_0_0_0_000_0100_1010, // R5 -> MCU_ONLY
        20'b0_0_0_00_0_0_0_0_000_0010_0000, // R9 ON drop -> STANDBY
        20'b0_1_0_00_0_0_0_0_000_0011_1110, // R3 ON -> ACTIVE
        20'b0_1_0_00_1_0_1_0_000_0111_0000, // R12 orderly over SoC error
        20'b0_1_0_00_0_0_0_0_000_1000_0000, // R10 -> SAFE_REC
        20'b1_1_0_00_0_0_0_0_000_0001_0000, // R2 re-entry
        20'b0_1_0_00_0_0_0_0_000_0010_0000  // R2 back to STANDBY
    };

    logic             clk;
    logic             rst_n;
    logic             fsm_entry_i;
    logic             on_req_i;
    logic             mode_vld_i;
    logic [1:0]       mode_i;
    logic             soc_err_i;
    logic             severe_i;
    logic             orderly_i;
    logic             cfg_wr_i;
    logic [2:0]       cfg_wdata_i;
    logic [CNT_W-1:0] seq_cycles_i;
    logic [3:0]       state_o;
    logic             mcu_en_o;
    logic             main_en_o;
    logic             ret_en_o;
    logic             drv_en_o;
    logic             ret_gpio_o;
    logic             ret_ddr_o;
    logic             busy_o;
    logic             safe_rec_o;
    logic             init_done_o;
    logic             rv_chk_dis_o;
    logic             uv_ov_mask_o;
    logic [2:0]       cfg_q_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    pwr_mode_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fsm_entry_i  (fsm_entry_i),
        .on_req_i     (on_req_i),
        .mode_vld_i   (mode_vld_i),
        .mode_i       (mode_i),
        .soc_err_i    (soc_err_i),
        .severe_i     (severe_i),
        .orderly_i    (orderly_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .seq_cycles_i (seq_cycles_i),
        .state_o      (state_o),
        .mcu_en_o     (mcu_en_o),
        .main_en_o    (main_en_o),
        .ret_en_o     (ret_en_o),
        .drv_en_o     (drv_en_o),
        .ret_gpio_o   (ret_gpio_o),
        .ret_ddr_o    (ret_ddr_o),
        .busy_o       (busy_o),
        .safe_rec_o   (safe_rec_o),
        .init_done_o  (init_done_o),
        .rv_chk_dis_o (rv_chk_dis_o),
        .uv_ov_mask_o (uv_ov_mask_o),
        .cfg_q_o      (cfg_q_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fsm_entry_i = 0; mode_vld_i = 0; mode_i = 0; soc_err_i = 0;
        severe_i = 0; orderly_i = 0; cfg_wr_i = 0; cfg_wdata_i = 0;
    endtask

    function automatic string vtag(input int i);
        case (i)
            0, 1, 22, 23: return "R2";
            2, 19:        return "R3";
            3, 15:        return "R4";
            4, 17:        return "R5";
            5, 11:        return "R6";
            6, 7, 8, 9, 10: return "R7";
            12, 13, 14:   return "R8";
            18:           return "R9";
            21:           return "R10";
            default:      return "R12";
        endcase
    endfunction

    initial begin
        rst_n = 0; on_req_i = 0; seq_cycles_i = '0;
        idle();
        repeat (3) step();
        // R1: reset values
        chk("R1 state", state_o, 4'd0);
        chk("R1 rails", {mcu_en_o, main_en_o, ret_en_o, drv_en_o, busy_o, safe_rec_o}, 6'b0);
        chk("R1 flags", {init_done_o, rv_chk_dis_o, uv_ov_mask_o, cfg_q_o}, 6'b001_000);
        rst_n = 1;
        step();
        chk("R1 after release", {state_o, uv_ov_mask_o}, 5'b0000_1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            fsm_entry_i = v[19]; on_req_i = v[18]; mode_vld_i = v[17];
            mode_i = v[16:15]; soc_err_i = v[14]; severe_i = v[13];
            orderly_i = v[12]; cfg_wr_i = v[11]; cfg_wdata_i = v[10:8];
            step();
            chk({vtag(i), " state"}, state_o, v[7:4]);
            chk({vtag(i), " rails"}, {mcu_en_o, main_en_o, ret_en_o, drv_en_o}, v[3:0]);
        end
        idle();

        // R2: initialization side effects
        chk("R2 init flags", {init_done_o, rv_chk_dis_o, uv_ov_mask_o}, 3'b110);

        // R8: DDR flavor sampled, driver bit cleared, later writes ignored
        step(); // STANDBY -> ACTIVE (on held high)
        cfg_wr_i = 1; cfg_wdata_i = 3'b101;
        step();
        cfg_wr_i = 0; mode_vld_i = 1; mode_i = 2'd2;
        step();
        mode_vld_i = 0;
        chk("R8 state", state_o, 4'd6);
        chk("R8 flavor", {ret_gpio_o, ret_ddr_o}, 2'b01);
        chk("R8 drv bit cleared", cfg_q_o, 3'b100);
        cfg_wr_i = 1; cfg_wdata_i = 3'b010;
        step();
        cfg_wr_i = 0;
        chk("R8 flavor held", {ret_gpio_o, ret_ddr_o, cfg_q_o}, 5'b01_010);
        mode_vld_i = 1; mode_i = 2'd0;
        step();
        mode_vld_i = 0;
        chk("R6 retention exit", state_o, 4'd3);

        // R11: busy window of 3 cycles defers a held request
        seq_cycles_i = 8'd3;
        mode_vld_i = 1; mode_i = 2'd1;
        step();
        chk("R11 busy set", {state_o, busy_o}, 5'b0100_1);
        mode_i = 2'd0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R11 deferred", state_o, 4'd4);
        end
        chk("R11 busy clear", busy_o, 1'b0);
        step();
        mode_vld_i = 0;
        chk("R11 taken after window", state_o, 4'd3);
        repeat (3) step();

        // R10: orderly shutdown lasts seq_cycles+1
        orderly_i = 1;
        step();
        orderly_i = 0;
        chk("R10 orderly entry", state_o, 4'd7);
        repeat (3) step();
        chk("R10 orderly still safe", state_o, 4'd7);
        step();
        chk("R10 recovery", {state_o, safe_rec_o}, 5'b1000_1);
        fsm_entry_i = 1;
        step();
        fsm_entry_i = 0;
        step();
        chk("R2 re-init", state_o, 4'd2);
        step();
        chk("R3 on from standby", state_o, 4'd3);
        repeat (3) step();

        // R12: severe wins over orderly and shuts down in one cycle
        severe_i = 1; orderly_i = 1;
        step();
        severe_i = 0; orderly_i = 0;
        chk("R12 severe entry", state_o, 4'd7);
        step();
        chk("R12 severe one cycle", {state_o, safe_rec_o}, 5'b1000_1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule